// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block sits on the receive byte stream of an Ethernet MAC. It watches the first six bytes of every incoming frame (the destination address) and decides whether the frame is kept or dropped. The decision combines five mode enables with a comparison against the station address, broadcast and IP-multicast detection, and a lookup in a 64-entry multicast hash table. The table is indexed by six bits of a CRC-32 computed over the destination address.

The block also raises an early-receive pulse once a programmable number of bytes of an accepted frame has arrived. The programmed threshold is raised to a floor of eight bytes, so that the address decision is always settled first. Larger values are rounded down to a multiple of four. A rejected frame never produces the pulse.

Frames are presented one byte per valid cycle. A start strobe marks the first byte. Storage of frame data and checking of the frame check sequence are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: `decision_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the sixth byte of a frame. The byte carrying `sof_i` counts as byte one, and idle cycles with `byte_valid_i` low are not counted. A frame restarted by `sof_i` before its sixth byte gives no decision.
- R2: With `mode_i[0]` set, the frame is accepted when the six destination bytes equal `station_addr_i`. The first byte on the wire is compared with `station_addr_i[47:40]`, and the sixth with `station_addr_i[7:0]`.
- R3: With `mode_i[1]` set, the frame is accepted when every destination byte is 0xFF.
- R4: With `mode_i[2]` set, a group destination (bit 0 of the first byte is 1) is accepted when `hash_table_i[idx]` is 1. The index `idx` is bits [31:26] of a CRC-32 register computed over the six destination bytes. The register uses polynomial 0x04C11DB7, is preset to all ones, shifts MSB first, takes the bits of each byte LSB first, and has no final inversion.
- R5: With `mode_i[3]` set, the frame is accepted when the first three destination bytes are 0x01, 0x00, 0x5E.
- R6: With `mode_i[4]` set, every frame is accepted.
- R7: A frame that meets no enabled rule is discarded (`accept_o` low with the decision). `accept_o` goes low on the edge that takes a `sof_i` byte and holds the latest decision until the next start.
- R8: The effective early threshold is `early_thresh_i` with bits [1:0] cleared, or 8 if that value is below 8. For an accepted frame, `early_o` pulses for one cycle after the edge that accepts byte number equal to the effective threshold.
- R9: `early_o` never rises for a discarded frame. It rises at most once per frame, and never for a frame shorter than the effective threshold.
- R10: After reset, `decision_valid_o`, `accept_o` and `early_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first byte of a frame; only with byte_valid_i |
| byte_valid_i | input | 1 | A frame byte is present on byte_i |
| byte_i | input | 8 | Received frame byte |
| station_addr_i | input | 48 | Own unicast address, first wire byte in [47:40] |
| hash_table_i | input | 64 | Multicast hash table, bit n selected by index n |
| mode_i | input | 5 | Enables: 0 unicast, 1 broadcast, 2 hash, 3 IP multicast, 4 promiscuous |
| early_thresh_i | input | 13 | Programmed early-receive byte threshold |
| decision_valid_o | output | 1 | One-cycle strobe: accept_o carries the frame decision |
| accept_o | output | 1 | Frame kept (1) or dropped (0) |
| early_o | output | 1 | One-cycle early-receive pulse for accepted frames |

## Verification
The assertions assume three things about the inputs:
- `sof_i` is only raised together with `byte_valid_i`.
- The mode, address, table and threshold inputs do not change while a frame is in flight.
- Frames are separated by a fresh start strobe.

The bench holds to these. Every configuration input is set between frames, and bytes are driven only from a task that sets the start strobe on the first byte alone. Gapped byte streams, aborted short frames and frames shorter than the threshold are generated within the same rules.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned HASH_W     = 6;
  localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;

  typedef enum logic [2:0] {
    MODE_UCAST  = 3'd0,
    MODE_BCAST  = 3'd1,
    MODE_HASH   = 3'd2,
    MODE_IPMC   = 3'd3,
    MODE_PROMIS = 3'd4
  } mode_bit_e;

  localparam int unsigned MODE_W = 5;

  // one byte into the CRC register, LSB of the byte first
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step (
  input  logic [31:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  import rxf_pkg::*;
  always_comb crc_o = crc_byte(crc_i, data_i);
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify #(
  parameter int unsigned HASH_W = 6,
  parameter int unsigned MODE_W = 5
) (
  input  logic [47:0]            dest_i,
  input  logic [47:0]            station_i,
  input  logic [(1<<HASH_W)-1:0] table_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [31:0]            crc_i,
  output logic                   accept_o
);
  import rxf_pkg::*;
  logic              is_ucast, is_bcast, is_group, is_ipmc, hash_hit;
  logic [HASH_W-1:0] hidx;

  always_comb begin
    hidx     = crc_i[31 -: HASH_W];
    is_ucast = (dest_i == station_i);
    is_bcast = &dest_i;
    is_group = dest_i[40];
    is_ipmc  = (dest_i[47:24] == 24'h01005E);
    hash_hit = is_group & table_i[hidx];
    accept_o = mode_i[MODE_PROMIS]
             | (mode_i[MODE_UCAST] & is_ucast)
             | (mode_i[MODE_BCAST] & is_bcast)
             | (mode_i[MODE_IPMC]  & is_ipmc)
             | (mode_i[MODE_HASH]  & hash_hit);
  end
endmodule

// File: rtl/rxf_early_thresh.sv
module rxf_early_thresh #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned MIN_THR = 8,
  parameter int unsigned QUANT_W = 2
) (
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] eff_o
);
  logic [CNT_W-1:0] q;
  always_comb begin
    q     = {thr_i[CNT_W-1:QUANT_W], {QUANT_W{1'b0}}};
    eff_o = (q < CNT_W'(MIN_THR)) ? CNT_W'(MIN_THR) : q;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned HASH_W  = 6,
  parameter int unsigned MIN_THR = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sof_i,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_i,
  input  logic [47:0]            station_addr_i,
  input  logic [(1<<HASH_W)-1:0] hash_table_i,
  input  logic [4:0]             mode_i,
  input  logic [CNT_W-1:0]       early_thresh_i,
  output logic                   decision_valid_o,
  output logic                   accept_o,
  output logic                   early_o
);
  import rxf_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_DST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, idx, cnt_d, eff_thr;
  logic [47:0]      dest_q, dest_full;
  logic [31:0]      crc_q, crc_in, crc_nx;
  logic             in_dst, last_dst, match;
  logic             dv_q, acc_q, early_q;

  always_comb begin
    idx       = sof_i ? '0 : cnt_q;
    cnt_d     = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
    crc_in    = sof_i ? 32'hFFFF_FFFF : crc_q;
    dest_full = {dest_q[39:0], byte_i};
    in_dst    = byte_valid_i && (idx <= LAST_DST);
    last_dst  = byte_valid_i && (idx == LAST_DST);
  end

  rxf_crc_step u_crc (.crc_i(crc_in), .data_i(byte_i), .crc_o(crc_nx));

  rxf_classify #(.HASH_W(HASH_W), .MODE_W(MODE_W)) u_cls (
    .dest_i(dest_full), .station_i(station_addr_i), .table_i(hash_table_i),
    .mode_i(mode_i), .crc_i(crc_nx), .accept_o(match)
  );

  rxf_early_thresh #(.CNT_W(CNT_W), .MIN_THR(MIN_THR), .QUANT_W(2)) u_thr (
    .thr_i(early_thresh_i), .eff_o(eff_thr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dest_q <= '0;
      crc_q  <= '1;
    end else if (byte_valid_i) begin
      cnt_q <= cnt_d;
      if (in_dst) begin
        dest_q <= dest_full;
        crc_q  <= crc_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q    <= 1'b0;
      acc_q   <= 1'b0;
      early_q <= 1'b0;
    end else begin
      dv_q    <= last_dst;
      early_q <= byte_valid_i && !sof_i && acc_q && (cnt_q != CNT_MAX) && (cnt_d == eff_thr);
      if (last_dst)                 acc_q <= match;
      else if (byte_valid_i && sof_i) acc_q <= 1'b0;
    end
  end

  assign decision_valid_o = dv_q;
  assign accept_o         = acc_q;
  assign early_o          = early_q;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sof_i,
  input logic       byte_valid_i,
  input logic [4:0] mode_i,
  input logic       decision_valid_o,
  input logic       accept_o,
  input logic       early_o
);
  logic [15:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (byte_valid_i)
      seen_q <= sof_i ? 16'd1 : ((seen_q == 16'hFFFF) ? seen_q : seen_q + 16'd1);
  end

  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);
  a_r6_promisc_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o && $past(mode_i[4]) |-> accept_o);
  a_r7_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && byte_valid_i |=> !accept_o && !decision_valid_o);
  a_r9_early_only_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> accept_o);
  a_r9_early_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |=> !early_o);
  a_r8_early_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> seen_q >= 16'd8);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .byte_valid_i(byte_valid_i),
  .mode_i(mode_i), .decision_valid_o(decision_valid_o), .accept_o(accept_o),
  .early_o(early_o)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  dbyte = '0;
  logic [47:0] sta = 48'h02_11_22_33_44_55;
  logic [63:0] ht = '0;
  logic [4:0]  mode = '0;
  logic [12:0] thr = '0;
  logic        dv, acc, early;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int dv_seen, dv_k, acc_at, early_seen, early_k;

  always #2 clk = ~clk;

  rx_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(vld), .byte_i(dbyte),
    .station_addr_i(sta), .hash_table_i(ht), .mode_i(mode), .early_thresh_i(thr),
    .decision_valid_o(dv), .accept_o(acc), .early_o(early)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic bit_in = d[47 - 8*b - 7 + i];
        logic top = c[31];
        c = c << 1;
        if (top ^ bit_in) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  function automatic bit model(input logic [47:0] d);
    return mode[4] || (mode[0] && d == sta) || (mode[1] && d == 48'hFFFF_FFFF_FFFF)
        || (mode[3] && d[47:24] == 24'h01005E) || (mode[2] && d[40] && ht[hidx(d)]);
  endfunction

  function automatic int eff_of(input logic [12:0] t);
    int q = int'(t) & ~3;
    return (q < 8) ? 8 : q;
  endfunction

  task automatic sample(input int k, input bit fresh);
    @(posedge clk); #1;
    if (dv) begin dv_seen++; dv_k = fresh ? k : -1; acc_at = acc; end
    if (early) begin early_seen++; early_k = fresh ? k : -1; end
  endtask

  task automatic send(input logic [47:0] d, input int len, input int gap);
    dv_seen = 0; dv_k = -1; acc_at = -1; early_seen = 0; early_k = -1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      vld = 1'b1; sof = (k == 1);
      dbyte = (k <= 6) ? d[47 - 8*(k-1) -: 8] : 8'(k);
      sample(k, 1'b1);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); vld = 1'b0; sof = 1'b0;
        sample(k, 1'b0);
      end
    end
    @(negedge clk); vld = 1'b0; sof = 1'b0;
    sample(0, 1'b0);
    sample(0, 1'b0);
  endtask

  task automatic run_frame(input string tag, input logic [47:0] d, input int len, input int gap);
    bit exp_acc = model(d);
    int eff = eff_of(thr);
    int exp_early = (exp_acc && len >= eff) ? 1 : 0;
    send(d, len, gap);
    check(dv_seen == 1 && dv_k == 6, {tag, " R1 decision strobe"}, dv_k, 6);
    check(acc_at == int'(exp_acc), {tag, " accept"}, acc_at, int'(exp_acc));
    check(early_seen == exp_early && (exp_early == 0 || early_k == eff),
          {tag, " R8/R9 early"}, early_k, exp_early ? eff : -1);
  endtask

  task automatic t_reset;
    check(dv == 0 && acc == 0 && early == 0, "R10 reset outputs", {dv, acc, early}, 0);
  endtask

  task automatic t_unicast;
    mode = 5'b00001; thr = 13'd0;
    run_frame("R2 unicast hit", sta, 12, 0);
    run_frame("R7 unicast miss", 48'h02_11_22_33_44_56, 12, 0);
  endtask

  task automatic t_bcast;
    mode = 5'b00010; thr = 13'd9;
    run_frame("R3 broadcast gapped", 48'hFFFF_FFFF_FFFF, 14, 1);
    mode = 5'b00001;
    run_frame("R7 broadcast disabled", 48'hFFFF_FFFF_FFFF, 10, 0);
  endtask

  task automatic t_hash;
    logic [47:0] m = 48'h01_80_C2_00_00_21;
    mode = 5'b00100; thr = 13'd13;
    ht = '0; ht[hidx(m)] = 1'b1;
    run_frame("R4 hash hit", m, 16, 0);
    ht = ~ht;
    run_frame("R4 hash miss", m, 16, 0);
    ht = '1;
    run_frame("R4 individual addr ignores hash", 48'h00_80_C2_00_00_21, 16, 0);
  endtask

  task automatic t_ipmc;
    mode = 5'b01000; thr = 13'd22;
    run_frame("R5 ip multicast", 48'h01_00_5E_12_34_56, 24, 0);
    run_frame("R5 near ip multicast", 48'h01_00_5F_12_34_56, 24, 0);
  endtask

  task automatic t_promisc;
    mode = 5'b10000; thr = 13'd5;
    run_frame("R6 promiscuous", 48'h3A_55_AA_01_02_03, 10, 2);
  endtask

  task automatic t_short;
    mode = 5'b10000; thr = 13'd40;
    run_frame("R9 frame below threshold", 48'h3A_55_AA_01_02_03, 20, 0);
    send(sta, 3, 0);
    check(dv_seen == 0, "R1 aborted short frame", dv_seen, 0);
    mode = 5'b00001;
    run_frame("R7 after abort", sta, 8, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_unicast();
    t_bcast();
    t_hash();
    t_ipmc();
    t_promisc();
    t_short();
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule